// File: doc/BRIEF.md
# Manchester Line Decoder with One-Shot Clock Recovery

This block takes a biphase serial line, in which each bit is the exclusive-OR of the data value with the bit clock, and recovers the data using a local clock that runs at a fixed multiple of the bit rate. The multiple is set by the `OVERSAMPLE` parameter, for example 16 or 32. The line first passes through a two-stage synchroniser. A change between consecutive synchronised samples is treated as a transition. An accepted transition starts a hold-off window of three quarters of a bit period. Transitions that arrive inside this window are discarded. This drops the cell-boundary transitions that appear between two equal bits, so the timing follows only the transitions at the centre of each bit cell.

Each accepted transition also takes a sample of the new line level, and that level becomes the decoded bit. The decoder checks how far apart accepted transitions are. A run of correctly spaced transitions declares lock. A transition that comes late, or a long silence on the line, removes lock and raises a loss-of-sync flag. Decoded bits are marked by a one-cycle strobe, and the strobe appears only while the decoder is locked.

Top module: `manchester_rx`

## Requirements
- R1: A mid-bit transition driven on `line_i` gives its `valid_o` strobe in the third clock cycle after the edge that first samples the new level. This delay comes from two synchroniser stages and one output register.
- R2: A transition that arrives fewer than `(3*OVERSAMPLE)/4` clock cycles after the previous accepted transition is ignored. With the default of 16 this is 12 cycles. An ignored transition does not change `data_o`, does not raise a strobe and does not move the timing reference.
- R3: On an accepted transition, `data_o` takes the line level after that transition. With `INVERT_SENSE=0`, a rising mid-bit transition decodes as 1 and a falling one as 0. `data_o` holds its value until the next accepted transition.
- R4: `valid_o` is high for exactly one cycle for each accepted transition, and only when the decoder was already locked and the transition was well timed.
- R5: An accepted transition is well timed when it arrives between `(3*OVERSAMPLE)/4` and `OVERSAMPLE + OVERSAMPLE/4` cycles after the previous accepted transition. Lock is declared on the 8th consecutive well-timed transition. The first transition after a loss of lock does not count, because it only serves as the reference.
- R6: An accepted transition that arrives later than `OVERSAMPLE + OVERSAMPLE/4` cycles clears lock. If the decoder was locked, it also sets `lost_o`.
- R7: If more than `OVERSAMPLE + OVERSAMPLE/2` cycles pass without an accepted transition, lock is cleared. If the decoder was locked, `lost_o` is also set.
- R8: `lost_o` stays set until lock is declared again, and it clears in that same cycle.
- R9: A synchronous active-high `rst` clears `data_o`, `valid_o`, `locked_o` and `lost_o`, and leaves the decoder with no timing reference.
- R10: During a run of equal bits, the cell-boundary transitions are rejected and every decoded bit still matches the transmitted bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock, `OVERSAMPLE` times the bit rate |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Asynchronous Manchester line |
| data_o | output | 1 | Most recently decoded bit |
| valid_o | output | 1 | One-cycle strobe for a new decoded bit while locked |
| locked_o | output | 1 | Decoder is locked to the mid-bit transitions |
| lost_o | output | 1 | Lock was lost and has not yet been regained |

## Verification
Errors in the hold-off count or in the gap counter show up at the ports within one bit period. Such an error can move the strobe off the third cycle after a mid-bit edge. It can also let a cell-boundary edge through, which flips `data_o` partway through a run of equal bits. An error in the lock counter shows up as `locked_o` rising one transition too early or too late during the preamble, or as strobes appearing before lock. Errors in timeout or late-edge handling show up within 25 cycles of silence, or on the first late edge, as `locked_o` or `lost_o` failing to change.

// File: rtl/mdec_pkg.sv
package mdec_pkg;

  // Number of cycles after an accepted edge during which further edges are ignored.
  function automatic int unsigned hold_ticks(input int unsigned ovs);
    return (3 * ovs) / 4;
  endfunction

  // Largest gap between accepted edges that still counts as well timed.
  function automatic int unsigned late_ticks(input int unsigned ovs);
    return ovs + ovs / 4;
  endfunction

  // Gap beyond which the line is treated as silent.
  function automatic int unsigned loss_ticks(input int unsigned ovs);
    return ovs + ovs / 2;
  endfunction

endpackage

// File: rtl/mdec_sync.sv
module mdec_sync (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic edge_o
);
  logic meta_q, stab_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b0;
      stab_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= line_i;
      stab_q <= meta_q;
      prev_q <= stab_q;
    end
  end

  assign level_o = stab_q;
  assign edge_o  = stab_q ^ prev_q;
endmodule

// File: rtl/mdec_timer.sv
module mdec_timer #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic edge_i,
  output logic accept_o,
  output logic on_time_o,
  output logic timeout_o
);
  localparam int unsigned HOLD = mdec_pkg::hold_ticks(OVERSAMPLE);
  localparam int unsigned LATE = mdec_pkg::late_ticks(OVERSAMPLE);
  localparam int unsigned LOSS = mdec_pkg::loss_ticks(OVERSAMPLE);
  localparam int unsigned SAT  = LOSS + 1;
  localparam int unsigned GW   = $clog2(SAT + 1);

  logic [GW-1:0] gap_q;

  assign accept_o  = edge_i && (gap_q >= GW'(HOLD));
  assign on_time_o = gap_q <= GW'(LATE);
  assign timeout_o = gap_q > GW'(LOSS);

  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q <= GW'(SAT);
    end else if (accept_o) begin
      gap_q <= GW'(1);
    end else if (gap_q != GW'(SAT)) begin
      gap_q <= gap_q + GW'(1);
    end
  end
endmodule

// File: rtl/mdec_lock.sv
module mdec_lock #(
  parameter int unsigned LOCK_EDGES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic accept_i,
  input  logic on_time_i,
  input  logic timeout_i,
  output logic locked_o,
  output logic lost_o
);
  localparam int unsigned CW = $clog2(LOCK_EDGES + 1);

  logic [CW-1:0] good_q;
  logic          locked_q, lost_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      good_q   <= '0;
      locked_q <= 1'b0;
      lost_q   <= 1'b0;
    end else if (accept_i && on_time_i) begin
      if (good_q == CW'(LOCK_EDGES - 1)) begin
        locked_q <= 1'b1;
        lost_q   <= 1'b0;
      end
      if (good_q != CW'(LOCK_EDGES)) good_q <= good_q + CW'(1);
    end else if (accept_i || timeout_i) begin
      good_q   <= '0;
      locked_q <= 1'b0;
      if (locked_q) lost_q <= 1'b1;
    end
  end

  assign locked_o = locked_q;
  assign lost_o   = lost_q;
endmodule

// File: rtl/manchester_rx.sv
module manchester_rx #(
  parameter int unsigned OVERSAMPLE   = 16,
  parameter int unsigned LOCK_EDGES   = 8,
  parameter bit          INVERT_SENSE = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic data_o,
  output logic valid_o,
  output logic locked_o,
  output logic lost_o
);
  logic level_w, edge_w, accept_w, on_time_w, timeout_w;
  logic data_q, valid_q;

  mdec_sync u_sync (
    .clk(clk), .rst(rst), .line_i(line_i),
    .level_o(level_w), .edge_o(edge_w)
  );

  mdec_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk(clk), .rst(rst), .edge_i(edge_w),
    .accept_o(accept_w), .on_time_o(on_time_w), .timeout_o(timeout_w)
  );

  mdec_lock #(.LOCK_EDGES(LOCK_EDGES)) u_lock (
    .clk(clk), .rst(rst), .accept_i(accept_w), .on_time_i(on_time_w),
    .timeout_i(timeout_w), .locked_o(locked_o), .lost_o(lost_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= accept_w && on_time_w && locked_o;
      if (accept_w) data_q <= level_w ^ INVERT_SENSE;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/mdec_checks.sv
module mdec_checks #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input logic clk,
  input logic rst,
  input logic accept_i,
  input logic timeout_i,
  input logic valid_i,
  input logic locked_i,
  input logic lost_i
);
  localparam int unsigned HOLD = mdec_pkg::hold_ticks(OVERSAMPLE);
  localparam int unsigned SW   = $clog2(HOLD + 1);

  // Independent count of cycles since the last accepted edge, saturating at HOLD.
  logic [SW-1:0] since_q;
  always_ff @(posedge clk) begin
    if (rst)                    since_q <= SW'(HOLD);
    else if (accept_i)          since_q <= SW'(1);
    else if (since_q < SW'(HOLD)) since_q <= since_q + SW'(1);
  end

  assert_holdoff_R2: assert property (@(posedge clk) disable iff (rst)
    accept_i |-> (since_q >= SW'(HOLD)));

  assert_strobe_locked_R4: assert property (@(posedge clk) disable iff (rst)
    valid_i |-> $past(locked_i));

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> !valid_i);

  assert_timeout_unlock_R7: assert property (@(posedge clk) disable iff (rst)
    timeout_i |=> !locked_i);

  assert_lost_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_i) |-> !lost_i);

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (!locked_i && !valid_i && !lost_i));
endmodule

bind manchester_rx mdec_checks #(.OVERSAMPLE(OVERSAMPLE)) u_checks (
  .clk(clk), .rst(rst), .accept_i(accept_w), .timeout_i(timeout_w),
  .valid_i(valid_o), .locked_i(locked_o), .lost_i(lost_o)
);

// File: tb/manchester_rx_test.sv
module manchester_rx_test;
  localparam int OVS   = 16;
  localparam int LOCKN = 8;
  localparam int HOLD  = OVS - OVS / 4;
  localparam int LATE  = OVS + OVS / 4;
  localparam int LOSS  = OVS + OVS / 2;

  logic clk = 1'b0, rst = 1'b1, line_i = 1'b0;
  logic data_o, valid_o, locked_o, lost_o;
  int checks = 0, fails = 0;
  bit run = 0, finished = 0;
  bit tx_bit = 0, last_b = 0;

  always #2 clk = ~clk;

  manchester_rx #(.OVERSAMPLE(OVS), .LOCK_EDGES(LOCKN), .INVERT_SENSE(1'b0)) uut (
    .clk(clk), .rst(rst), .line_i(line_i), .data_o(data_o),
    .valid_o(valid_o), .locked_o(locked_o), .lost_o(lost_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  // Behavioural reference: line history queue and integer counters.
  int q[$];
  int m_gap, m_good;
  bit m_locked, m_lost, m_data, m_valid;

  always @(posedge clk) begin
    if (rst) begin
      q = '{0, 0, 0};
      m_gap = LOSS + 1; m_good = 0;
      m_locked = 0; m_lost = 0; m_data = 0; m_valid = 0;
    end else begin
      bit e, acc, wt;
      int lvl;
      lvl = q[1];
      e   = (q[1] != q[2]);
      acc = e && (m_gap >= HOLD);
      wt  = (m_gap <= LATE);
      m_valid = acc && wt && m_locked;
      if (acc) begin
        m_data = lvl[0];
        if (wt) begin
          if (m_good == LOCKN - 1) begin m_locked = 1; m_lost = 0; end
          if (m_good < LOCKN) m_good++;
        end else begin
          if (m_locked) m_lost = 1;
          m_locked = 0; m_good = 0;
        end
        m_gap = 1;
      end else begin
        if (m_gap > LOSS) begin
          if (m_locked) m_lost = 1;
          m_locked = 0; m_good = 0;
        end else m_gap++;
      end
      q.push_front(int'(line_i));
      void'(q.pop_back());
    end
  end

  always @(negedge clk) begin
    if (run && !finished) begin
      chk(valid_o == m_valid, "R4 valid", valid_o, m_valid);
      chk(data_o == m_data, "R3 data", data_o, m_data);
      chk(locked_o == m_locked, "R5 locked", locked_o, m_locked);
      chk(lost_o == m_lost, "R7 lost", lost_o, m_lost);
      if (valid_o) chk(data_o == tx_bit, "R10 decoded bit vs sent", data_o, tx_bit);
    end
  end

  // One bit cell: first half !b, second half b; optional latency check (R1).
  task automatic send_bit(input bit b, input int h1, input int h2, input bit lat);
    line_i = !b;
    repeat (h1) @(negedge clk);
    line_i = b;
    tx_bit = b;
    for (int k = 1; k <= h2; k++) begin
      @(negedge clk);
      if (lat) chk(valid_o == (k == 3), "R1 strobe latency", valid_o, (k == 3));
    end
    last_b = b;
  endtask

  // Bit with a short glitch inside the hold-off window (R2).
  task automatic send_glitch_bit(input bit b);
    line_i = !b;
    repeat (8) @(negedge clk);
    line_i = b; tx_bit = b;
    repeat (4) @(negedge clk);
    line_i = !b;
    @(negedge clk);
    line_i = b;
    repeat (3) @(negedge clk);
    last_b = b;
  endtask

  // Alternating bits; the first is chosen so the cell starts at the current level.
  task automatic preamble(input int n);
    bit b;
    b = !line_i;
    for (int i = 0; i < n; i++) begin
      send_bit(b, 8, 8, 0);
      b = !b;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(!locked_o && !valid_o && !lost_o && !data_o, "R9 reset state",
        {locked_o, valid_o, lost_o, data_o}, 0);
    run = 1;

    // R5: reference + 7 well-timed edges is not enough, the 8th locks
    preamble(8);
    chk(locked_o == 1'b0, "R5 not yet locked", locked_o, 0);
    send_bit(!last_b, 8, 8, 0);
    chk(locked_o == 1'b1, "R5 locked after 8 edges", locked_o, 1);

    // R1 latency on alternating bits
    for (int i = 0; i < 4; i++) send_bit(!last_b, 8, 8, 1);

    // R3 random data with small timing jitter
    for (int i = 0; i < 24; i++)
      send_bit(1'($urandom_range(0, 1)), $urandom_range(7, 9), $urandom_range(7, 9), 0);

    // R10 runs of equal bits
    for (int i = 0; i < 16; i++) send_bit(1'b1, 8, 8, 1);
    for (int i = 0; i < 16; i++) send_bit(1'b0, 8, 8, 1);

    // R2 glitches inside the hold-off window
    for (int i = 0; i < 4; i++) send_glitch_bit(i[0]);
    send_bit(1'b1, 8, 8, 0);
    chk(locked_o == 1'b1, "R2 lock kept through glitches", locked_o, 1);

    // R6 late edge (gap 22)
    send_bit(last_b, 14, 8, 0);
    chk(locked_o == 1'b0, "R6 late edge unlocks", locked_o, 0);
    chk(lost_o == 1'b1, "R6 late edge sets lost", lost_o, 1);

    // R8 relock clears lost
    preamble(10);
    chk(locked_o == 1'b1, "R8 relocked", locked_o, 1);
    chk(lost_o == 1'b0, "R8 lost cleared", lost_o, 0);

    // R7 silence beyond the loss limit
    repeat (40) @(negedge clk);
    chk(locked_o == 1'b0, "R7 timeout unlocks", locked_o, 0);
    chk(lost_o == 1'b1, "R7 timeout sets lost", lost_o, 1);
    chk(valid_o == 1'b0, "R4 no strobe while unlocked", valid_o, 0);

    preamble(10);
    for (int i = 0; i < 10; i++) send_bit(1'($urandom_range(0, 1)), 8, 8, 0);
    chk(locked_o == 1'b1, "R5 final lock", locked_o, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule